// File: doc/BRIEF.md
# Dual-Page-Size Translation Cache

This block holds recently used virtual-to-physical page translations for a processor that maps memory with two page sizes, 4 KB and 4 MB. Each size has its own 4-way set-associative array. The small-page array has 16 sets and the large-page array has 2. Every lookup presents a virtual page number (the virtual address with its 12 offset bits removed). Both arrays are probed in parallel. In the same cycle the block reports a single hit, the physical frame number, the attribute flags and the global bit of the entry that matched.

When a lookup misses, the page-table walker outside this block finds the translation and installs it through the fill port. The fill names the page size, and that choice decides which array takes the entry. Within a set, an empty way is used before any valid entry is replaced. When every way is valid, a 3-bit tree pseudo-LRU picks the victim. There are two ways to remove entries. An address-space switch flushes every entry whose global bit is clear. A single-page invalidate removes one page from both arrays.

Top module: `xlat_cache`

## Requirements
- R1: A synchronous active-high reset leaves every entry invalid, so every lookup after reset misses, including lookups of pages filled before the reset.
- R2: The small array uses vpn[3:0] as its set index and vpn[19:4] as its tag. A small-page hit returns the stored 20-bit frame unchanged, in the same cycle the page number is presented. A fill becomes visible on the cycle after its clock edge.
- R3: The large array uses vpn[10] as its set index and vpn[19:11] as its tag, and stores only fl_frame[19:10]. On a large-page hit the frame output is the stored 10 bits above vpn[9:0], and lk_big is 1.
- R4: Both arrays are probed on every lookup. If both hit, the small-page entry is reported and lk_big is 0.
- R5: A fill with fl_large=0 goes to the small array and one with fl_large=1 goes to the large array. A fill of a page already resident in that array overwrites that entry in place, so the new frame is returned afterwards.
- R6: A fill into a set with an invalid way uses the lowest-numbered invalid way, whatever the replacement state says.
- R7: With all four ways valid, the victim is chosen by tree pseudo-LRU. A fill marks its way as used, and so does a lookup with lk_req=1 that hits. After fills to ways 0, 1, 2, 3 and then a used hit on way 0, the next fill replaces way 2.
- R8: A pulse on inv_all invalidates every entry whose global bit is 0 in both arrays. Global entries stay valid.
- R9: A pulse on inv_one removes the entry for inv_vpn from each array where it is resident, even if it is global.
- R10: A hit returns the flags and global bit given at fill time. On a miss, lk_frame, lk_flags, lk_glob and lk_big are all 0.
- R11: A fill in the same cycle as inv_all or inv_one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup is a real access; a hit updates replacement state |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found in either array |
| lk_big | output | 1 | Hit came from the 4 MB array |
| lk_frame | output | 20 | Physical frame number (4 KB granularity) |
| lk_flags | output | 4 | Attribute flags of the hit entry |
| lk_glob | output | 1 | Global bit of the hit entry |
| fl_valid | input | 1 | Install a translation this cycle |
| fl_large | input | 1 | Page size of the fill: 0 = 4 KB, 1 = 4 MB |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_frame | input | 20 | Physical frame number of the fill |
| fl_flags | input | 4 | Attribute flags of the fill |
| fl_glob | input | 1 | Global bit of the fill |
| inv_all | input | 1 | Flush all non-global entries |
| inv_one | input | 1 | Remove the page named by inv_vpn |
| inv_vpn | input | 20 | Page number to remove |

## Verification
The bench fills one small-page set to capacity, marks way 0 as used with a lookup, and fills again. It then checks that the third-filled page is the one that disappears. A FIFO or round-robin replacer would evict the first page instead. After an invalidate empties way 3, the next fill must land there and not on the pseudo-LRU victim (way 1), so a design that ignores empty ways loses a live page. Refilling a resident page must replace its frame. A design that writes a duplicate way returns a corrupted, OR-merged frame. A large page covered by an overlapping small page shows whether the small hit wins and whether the low frame bits come from the page number. The flush tests show whether the global bit is honoured by inv_all and ignored by inv_one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = 2;
  localparam int unsigned TREE_W = 3;

  typedef logic [TREE_W-1:0] tree_t;
  typedef logic [WAY_W-1:0]  way_t;

  // bit0 selects the half, bit1 the way in ways 0/1, bit2 the way in ways 2/3
  function automatic way_t tree_victim(tree_t t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  // point every node on the path away from the way just used
  function automatic tree_t tree_touch(tree_t t, way_t w);
    tree_t n;
    n    = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic way_t lowest_set(logic [WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/xlat_plru.sv
module xlat_plru
  import xlat_pkg::*;
#(
  parameter int unsigned SETS = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_set,
  input  way_t             use_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  way_t             fill_way,
  input  logic [IDX_W-1:0] q_set,
  output way_t             q_victim
);

  tree_t st_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (use_en)  st_q[use_set]  <= tree_touch(st_q[use_set], use_way);
      if (fill_en) st_q[fill_set] <= tree_touch(st_q[fill_set], fill_way);
    end
  end

  assign q_victim = tree_victim(st_q[q_set]);

endmodule

// File: rtl/xlat_way_array.sv
module xlat_way_array
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned SETS    = 16,
  parameter int unsigned IDX_LSB = 0,
  parameter int unsigned DATA_W  = 25,
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W,
  localparam int unsigned TAG_W   = VPN_W - TAG_LSB
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VPN_W-1:IDX_LSB]   lk_va,
  input  logic                     lk_use,
  output logic                     lk_hit,
  output logic [DATA_W-1:0]        lk_data,
  input  logic                     fl_en,
  input  logic [VPN_W-1:IDX_LSB]   fl_va,
  input  logic [DATA_W-1:0]        fl_data,
  input  logic                     inv_all,
  input  logic                     inv_one,
  input  logic [VPN_W-1:IDX_LSB]   inv_va
);

  // the top bit of each data word is the global flag
  localparam int unsigned GLB = DATA_W - 1;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   vld_d [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, fl_set, inv_set;
  logic [TAG_W-1:0] lk_tag, fl_tag, inv_tag;
  logic [WAYS-1:0]  lk_hitv, fl_hitv, inv_hitv;
  way_t             lk_way, fl_way, victim;

  assign lk_set  = lk_va[TAG_LSB-1:IDX_LSB];
  assign fl_set  = fl_va[TAG_LSB-1:IDX_LSB];
  assign inv_set = inv_va[TAG_LSB-1:IDX_LSB];
  assign lk_tag  = lk_va[VPN_W-1:TAG_LSB];
  assign fl_tag  = fl_va[VPN_W-1:TAG_LSB];
  assign inv_tag = inv_va[VPN_W-1:TAG_LSB];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hitv[w]  = vld_q[lk_set][w]  && (tag_q[lk_set][w]  == lk_tag);
    assign fl_hitv[w]  = vld_q[fl_set][w]  && (tag_q[fl_set][w]  == fl_tag);
    assign inv_hitv[w] = vld_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag);
  end

  assign lk_hit = |lk_hitv;
  assign lk_way = lowest_set(lk_hitv);

  always_comb begin
    lk_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hitv[w]) lk_data = lk_data | dat_q[lk_set][w];
    end
  end

  // resident page first, then an empty way, then the tree victim
  always_comb begin
    if (|fl_hitv)                fl_way = lowest_set(fl_hitv);
    else if (~&vld_q[fl_set])    fl_way = lowest_set(~vld_q[fl_set]);
    else                         fl_way = victim;
  end

  xlat_plru #(.SETS(SETS)) plru_i (
    .clk      (clk),
    .rst      (rst),
    .use_en   (lk_use && lk_hit),
    .use_set  (lk_set),
    .use_way  (lk_way),
    .fill_en  (fl_en),
    .fill_set (fl_set),
    .fill_way (fl_way),
    .q_set    (fl_set),
    .q_victim (victim)
  );

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        vld_d[s][w] = vld_q[s][w];
        if (inv_all && !dat_q[s][w][GLB]) vld_d[s][w] = 1'b0;
        if (inv_one && inv_set == IDX_W'(s) && inv_hitv[w]) vld_d[s][w] = 1'b0;
        if (fl_en && fl_set == IDX_W'(s) && fl_way == WAY_W'(w)) vld_d[s][w] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= vld_d[s];
    end
  end

  // tag and data storage carry no reset
  always_ff @(posedge clk) begin
    if (fl_en) begin
      tag_q[fl_set][fl_way] <= fl_tag;
      dat_q[fl_set][fl_way] <= fl_data;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W    = 20,
  parameter int unsigned FRAME_W  = 20,
  parameter int unsigned FLAG_W   = 4,
  parameter int unsigned SM_SETS  = 16,
  parameter int unsigned BG_SETS  = 2,
  parameter int unsigned BIG_SPAN = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic               lk_big,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [FLAG_W-1:0]  lk_flags,
  output logic               lk_glob,
  input  logic               fl_valid,
  input  logic               fl_large,
  input  logic [VPN_W-1:0]   fl_vpn,
  input  logic [FRAME_W-1:0] fl_frame,
  input  logic [FLAG_W-1:0]  fl_flags,
  input  logic               fl_glob,
  input  logic               inv_all,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn
);

  localparam int unsigned BG_FRAME_W = FRAME_W - BIG_SPAN;
  localparam int unsigned SM_DATA_W  = 1 + FLAG_W + FRAME_W;
  localparam int unsigned BG_DATA_W  = 1 + FLAG_W + BG_FRAME_W;

  logic                 fl_go;
  logic                 sm_hit, bg_hit;
  logic [SM_DATA_W-1:0] sm_data;
  logic [BG_DATA_W-1:0] bg_data;

  assign fl_go = fl_valid && !inv_all && !inv_one;

  xlat_way_array #(
    .VPN_W(VPN_W), .SETS(SM_SETS), .IDX_LSB(0), .DATA_W(SM_DATA_W)
  ) small_i (
    .clk     (clk),
    .rst     (rst),
    .lk_va   (lk_vpn),
    .lk_use  (lk_req),
    .lk_hit  (sm_hit),
    .lk_data (sm_data),
    .fl_en   (fl_go && !fl_large),
    .fl_va   (fl_vpn),
    .fl_data ({fl_glob, fl_flags, fl_frame}),
    .inv_all (inv_all),
    .inv_one (inv_one),
    .inv_va  (inv_vpn)
  );

  xlat_way_array #(
    .VPN_W(VPN_W), .SETS(BG_SETS), .IDX_LSB(BIG_SPAN), .DATA_W(BG_DATA_W)
  ) large_i (
    .clk     (clk),
    .rst     (rst),
    .lk_va   (lk_vpn[VPN_W-1:BIG_SPAN]),
    .lk_use  (lk_req),
    .lk_hit  (bg_hit),
    .lk_data (bg_data),
    .fl_en   (fl_go && fl_large),
    .fl_va   (fl_vpn[VPN_W-1:BIG_SPAN]),
    .fl_data ({fl_glob, fl_flags, fl_frame[FRAME_W-1:BIG_SPAN]}),
    .inv_all (inv_all),
    .inv_one (inv_one),
    .inv_va  (inv_vpn[VPN_W-1:BIG_SPAN])
  );

  always_comb begin
    lk_hit   = 1'b0;
    lk_big   = 1'b0;
    lk_frame = '0;
    lk_flags = '0;
    lk_glob  = 1'b0;
    if (sm_hit) begin
      lk_hit   = 1'b1;
      lk_frame = sm_data[FRAME_W-1:0];
      lk_flags = sm_data[FRAME_W +: FLAG_W];
      lk_glob  = sm_data[SM_DATA_W-1];
    end else if (bg_hit) begin
      lk_hit   = 1'b1;
      lk_big   = 1'b1;
      lk_frame = {bg_data[BG_FRAME_W-1:0], lk_vpn[BIG_SPAN-1:0]};
      lk_flags = bg_data[BG_FRAME_W +: FLAG_W];
      lk_glob  = bg_data[BG_DATA_W-1];
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned FLAG_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic               lk_big,
  input logic [FRAME_W-1:0] lk_frame,
  input logic [FLAG_W-1:0]  lk_flags,
  input logic               lk_glob,
  input logic               fl_valid,
  input logic [VPN_W-1:0]   fl_vpn,
  input logic               inv_all,
  input logic               inv_one,
  input logic [VPN_W-1:0]   inv_vpn
);

  p_reset_miss_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fl_valid && !inv_all && !inv_one) && lk_vpn == $past(fl_vpn))
      |-> lk_hit);

  p_flush_keeps_global_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_all) && lk_hit) |-> lk_glob);

  p_page_removed_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_one) && lk_vpn == $past(inv_vpn)) |-> !lk_hit);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_frame == '0 && lk_flags == '0 && !lk_glob && !lk_big));

endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W), .FRAME_W(FRAME_W), .FLAG_W(FLAG_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .lk_vpn   (lk_vpn),
  .lk_hit   (lk_hit),
  .lk_big   (lk_big),
  .lk_frame (lk_frame),
  .lk_flags (lk_flags),
  .lk_glob  (lk_glob),
  .fl_valid (fl_valid),
  .fl_vpn   (fl_vpn),
  .inv_all  (inv_all),
  .inv_one  (inv_one),
  .inv_vpn  (inv_vpn)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;

  localparam logic [2:0] OP_FIL = 3'd0;  // fill
  localparam logic [2:0] OP_LKR = 3'd1;  // lookup that counts as use
  localparam logic [2:0] OP_LKN = 3'd2;  // lookup without use
  localparam logic [2:0] OP_IVA = 3'd3;  // flush non-global
  localparam logic [2:0] OP_IV1 = 3'd4;  // single page invalidate

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  rq;
    logic        lg;
    logic        gl;
    logic [19:0] vpn;
    logic [19:0] fr;
    logic        eh;
    logic        eb;
    logic [19:0] ef;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{OP_LKN, 4'd1,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b0, 1'b0, 20'h00000}, // R1
    '{OP_FIL, 4'd2,  1'b0, 1'b0, 20'h00015, 20'h11111, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd2,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b1, 1'b0, 20'h11111}, // R2
    '{OP_LKN, 4'd2,  1'b0, 1'b0, 20'h00016, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_FIL, 4'd6,  1'b0, 1'b0, 20'h00025, 20'h22222, 1'b0, 1'b0, 20'h00000},
    '{OP_FIL, 4'd6,  1'b0, 1'b0, 20'h00035, 20'h33333, 1'b0, 1'b0, 20'h00000},
    '{OP_FIL, 4'd6,  1'b0, 1'b0, 20'h00045, 20'h44444, 1'b0, 1'b0, 20'h00000},
    '{OP_LKR, 4'd7,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b1, 1'b0, 20'h11111},
    '{OP_FIL, 4'd7,  1'b0, 1'b0, 20'h00055, 20'h55555, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd7,  1'b0, 1'b0, 20'h00035, 20'h00000, 1'b0, 1'b0, 20'h00000}, // R7 way2 evicted
    '{OP_LKN, 4'd7,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b1, 1'b0, 20'h11111},
    '{OP_LKN, 4'd7,  1'b0, 1'b0, 20'h00025, 20'h00000, 1'b1, 1'b0, 20'h22222},
    '{OP_LKN, 4'd7,  1'b0, 1'b0, 20'h00045, 20'h00000, 1'b1, 1'b0, 20'h44444},
    '{OP_LKN, 4'd7,  1'b0, 1'b0, 20'h00055, 20'h00000, 1'b1, 1'b0, 20'h55555},
    '{OP_IV1, 4'd9,  1'b0, 1'b0, 20'h00045, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd9,  1'b0, 1'b0, 20'h00045, 20'h00000, 1'b0, 1'b0, 20'h00000}, // R9
    '{OP_FIL, 4'd6,  1'b0, 1'b0, 20'h00065, 20'h66666, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd6,  1'b0, 1'b0, 20'h00025, 20'h00000, 1'b1, 1'b0, 20'h22222}, // R6
    '{OP_LKN, 4'd6,  1'b0, 1'b0, 20'h00065, 20'h00000, 1'b1, 1'b0, 20'h66666},
    '{OP_FIL, 4'd5,  1'b0, 1'b0, 20'h00015, 20'h77777, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd5,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b1, 1'b0, 20'h77777}, // R5
    '{OP_FIL, 4'd3,  1'b1, 1'b0, 20'h08400, 20'hABC00, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd3,  1'b0, 1'b0, 20'h08456, 20'h00000, 1'b1, 1'b1, 20'hABC56}, // R3
    '{OP_LKN, 4'd3,  1'b0, 1'b0, 20'h08056, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_FIL, 4'd4,  1'b0, 1'b0, 20'h08456, 20'h12345, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd4,  1'b0, 1'b0, 20'h08456, 20'h00000, 1'b1, 1'b0, 20'h12345}, // R4
    '{OP_LKN, 4'd4,  1'b0, 1'b0, 20'h08457, 20'h00000, 1'b1, 1'b1, 20'hABC57},
    '{OP_FIL, 4'd8,  1'b0, 1'b1, 20'h00091, 20'h0AAAA, 1'b0, 1'b0, 20'h00000},
    '{OP_IVA, 4'd8,  1'b0, 1'b0, 20'h00000, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd8,  1'b0, 1'b0, 20'h00091, 20'h00000, 1'b1, 1'b0, 20'h0AAAA}, // R8
    '{OP_LKN, 4'd8,  1'b0, 1'b0, 20'h00015, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd8,  1'b0, 1'b0, 20'h08457, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_FIL, 4'd9,  1'b1, 1'b1, 20'h10000, 20'h40000, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd9,  1'b0, 1'b0, 20'h10000, 20'h00000, 1'b1, 1'b1, 20'h40000},
    '{OP_IV1, 4'd9,  1'b0, 1'b0, 20'h10123, 20'h00000, 1'b0, 1'b0, 20'h00000},
    '{OP_LKN, 4'd9,  1'b0, 1'b0, 20'h10000, 20'h00000, 1'b0, 1'b0, 20'h00000}  // R9
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req;
  logic [19:0] lk_vpn;
  logic        lk_hit, lk_big, lk_glob;
  logic [19:0] lk_frame;
  logic [3:0]  lk_flags;
  logic        fl_valid, fl_large, fl_glob;
  logic [19:0] fl_vpn, fl_frame;
  logic [3:0]  fl_flags;
  logic        inv_all, inv_one;
  logic [19:0] inv_vpn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_big(lk_big), .lk_frame(lk_frame),
    .lk_flags(lk_flags), .lk_glob(lk_glob),
    .fl_valid(fl_valid), .fl_large(fl_large), .fl_vpn(fl_vpn),
    .fl_frame(fl_frame), .fl_flags(fl_flags), .fl_glob(fl_glob),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_req = 1'b0; lk_vpn = '0;
    fl_valid = 1'b0; fl_large = 1'b0; fl_vpn = '0; fl_frame = '0;
    fl_flags = '0; fl_glob = 1'b0;
    inv_all = 1'b0; inv_one = 1'b0; inv_vpn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 and R10: empty after reset, outputs zero on miss
    check(!lk_hit, "R1", "hit after reset", 32'(lk_hit), 32'd0);
    check(lk_frame == '0 && lk_flags == '0 && !lk_glob && !lk_big, "R10",
          "miss outputs", {lk_glob, lk_big, lk_flags, lk_frame}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VECS[i].op)
        OP_FIL: begin
          fl_valid = 1'b1; fl_large = VECS[i].lg; fl_glob = VECS[i].gl;
          fl_vpn = VECS[i].vpn; fl_frame = VECS[i].fr; fl_flags = VECS[i].fr[3:0];
        end
        OP_IVA: inv_all = 1'b1;
        OP_IV1: begin inv_one = 1'b1; inv_vpn = VECS[i].vpn; end
        default: begin
          lk_vpn = VECS[i].vpn;
          lk_req = (VECS[i].op == OP_LKR);
        end
      endcase
      if (VECS[i].op == OP_LKR || VECS[i].op == OP_LKN) begin
        #1;
        check(lk_hit == VECS[i].eh, $sformatf("R%0d", VECS[i].rq),
              $sformatf("hit vec %0d", i), 32'(lk_hit), 32'(VECS[i].eh));
        if (VECS[i].eh) begin
          check(lk_big == VECS[i].eb, $sformatf("R%0d", VECS[i].rq),
                $sformatf("size vec %0d", i), 32'(lk_big), 32'(VECS[i].eb));
          check(lk_frame == VECS[i].ef, $sformatf("R%0d", VECS[i].rq),
                $sformatf("frame vec %0d", i), 32'(lk_frame), 32'(VECS[i].ef));
        end
      end
    end

    // R10: flags and global bit come back with the hit
    @(negedge clk);
    idle();
    fl_valid = 1'b1; fl_vpn = 20'h00AB3; fl_frame = 20'h13579; fl_flags = 4'hA; fl_glob = 1'b1;
    @(negedge clk);
    idle();
    lk_vpn = 20'h00AB3;
    #1;
    check(lk_hit && lk_flags == 4'hA && lk_glob, "R10", "flags and global",
          {27'd0, lk_glob, lk_flags}, {27'd0, 1'b1, 4'hA});

    // R11: fill coinciding with a flush is dropped
    @(negedge clk);
    idle();
    fl_valid = 1'b1; fl_vpn = 20'h00CC4; fl_frame = 20'h0BEEF; inv_all = 1'b1;
    @(negedge clk);
    idle();
    lk_vpn = 20'h00CC4;
    #1;
    check(!lk_hit, "R11", "fill during flush", 32'(lk_hit), 32'd0);

    // R1: a reset in mid-run empties the arrays, global entries included
    @(negedge clk);
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    lk_vpn = 20'h00AB3;
    #1;
    check(!lk_hit, "R1", "hit after second reset", 32'(lk_hit), 32'd0);

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule